// File: doc/BRIEF.md
# Write-only I2C command receiver

This block is a receive-only target on a two-wire I2C bus. It oversamples SCL and SDA with the system clock, recognises bus START and STOP conditions, and compares the 7-bit target address of each transaction with a local address driven on an input port and with one fixed broadcast address. A write addressed to either of them is accepted. The block then takes exactly three data bytes and hands them on as one 24-bit command word.

The output side is a valid-only stream: `cmd_valid_o` pulses for one clock while `cmd_word_o` carries the word. The word stays on `cmd_word_o` until the next complete frame. There is no ready input and no back-pressure. The bus cannot be held off because clock stretching is not supported, so the consumer must take each word in the cycle its strobe is high. Reads are refused, and so is any data byte beyond the third. Frames cut short by a STOP or a repeated START are dropped.

The SDA output is an open-drain enable: `sda_pull_o` high means "pull the line low". Outside the acknowledge slots that the block grants, it stays low.

Top module: `i2c_cmd_sink`

## Requirements
- R1: After reset `sda_pull_o`, `cmd_valid_o` and `cmd_word_o` are all 0.
- R2: A first byte after START whose upper seven bits equal `own_addr_i` and whose bit 0 (direction) is 0 is acknowledged. SDA is pulled low for the whole high phase of the 9th SCL clock, and the pull changes only while SCL is low.
- R3: A write to the fixed broadcast address 7'h73 (first byte 8'hE6) is acknowledged like a local write.
- R4: A first byte with direction bit 1 is never acknowledged, even if the address matches. Later bytes of that transaction are not acknowledged and produce no strobe.
- R5: A first byte whose address matches neither address is not acknowledged. Its later bytes are not acknowledged and produce no strobe.
- R6: The first three data bytes of an accepted write are each acknowledged. After the third, `cmd_word_o` = {byte1, byte2, byte3}, so byte1 sits in bits [23:16] (command in [23:20], channel in [19:16]) and bytes 2 and 3 form the data word in [15:0]. Each byte arrives MSB first.
- R7: Data bytes after the third in the same transaction are not acknowledged, raise no strobe and leave `cmd_word_o` unchanged.
- R8: A STOP after fewer than three data bytes raises no strobe and leaves `cmd_word_o` unchanged.
- R9: A repeated START restarts address reception and discards collected data bytes. The word that follows is built only from bytes sent after it.
- R10: A START or STOP in the middle of a byte discards the bits received so far. After a START the next byte is read as an address.
- R11: `cmd_valid_o` is high for exactly one clock per complete frame and never for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL bus level |
| sda_i | input | 1 | Sensed SDA bus level |
| own_addr_i | input | 7 | Local 7-bit target address |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| cmd_valid_o | output | 1 | One-clock strobe for a new command word |
| cmd_word_o | output | 24 | Last complete command word |

## Verification
A wrong bit or byte count shows up at the ports within one byte time. The acknowledge pull lands on the wrong SCL high phase, or turns up during a data bit. A reference model in the bench checks the pull on every SCL-high cycle, so the fault is reported within about nine SCL periods. A wrong frame state or byte counter shows up as a strobe that is missing, extra or doubled, or as a misassembled word. The bench compares these against a queue of expected words in every cycle. Checks after each STOP catch any strobe that was never raised.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  typedef enum logic [1:0] {
    FR_IDLE,
    FR_ADDR,
    FR_DATA,
    FR_SKIP
  } frame_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o,
  output logic [LINES-1:0] prev_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain  <= '1;
        prev_r <= 1'b1;
      end else begin
        chain  <= {chain[STAGES-2:0], raw_i[g]};
        prev_r <= chain[STAGES-1];
      end
    end
    assign sync_o[g] = chain[STAGES-1];
    assign prev_o[g] = prev_r;
  end
endmodule

// File: rtl/i2c_bit_shifter.sv
module i2c_bit_shifter #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_done_o,
  output logic              ack_end_o,
  output logic              in_ack_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  logic [CNT_W-1:0] cnt;

  assign byte_done_o = !clear_i && scl_fall_i && !in_ack_o && (cnt == FULL);
  assign ack_end_o   = !clear_i && scl_fall_i && in_ack_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      in_ack_o <= 1'b0;
      byte_o   <= '0;
    end else if (clear_i) begin
      cnt      <= '0;
      in_ack_o <= 1'b0;
    end else if (byte_done_o) begin
      in_ack_o <= 1'b1;
    end else if (ack_end_o) begin
      in_ack_o <= 1'b0;
      cnt      <= '0;
    end else if (scl_rise_i && !in_ack_o && (cnt != FULL)) begin
      byte_o <= {byte_o[BYTE_W-2:0], sda_i};
      cnt    <= cnt + CNT_W'(1);
    end
  end

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt == '0) && !in_ack_o);
endmodule

// File: rtl/i2c_cmd_sink.sv
module i2c_cmd_sink
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] GLOBAL_ADDR = 7'h73,
  parameter int FRAME_BYTES = 3,
  parameter int SYNC_STAGES = 2,
  localparam int BYTE_W = 8,
  localparam int WORD_W = BYTE_W * FRAME_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [6:0]        own_addr_i,
  output logic              sda_pull_o,
  output logic              cmd_valid_o,
  output logic [WORD_W-1:0] cmd_word_o
);
  localparam int CNT_W = $clog2(FRAME_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BYTES - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BYTES);

  logic [1:0] line_s, line_q;
  logic scl_s, sda_s, scl_q, sda_q;
  logic start_ev, stop_ev, scl_rise, scl_fall;
  logic [BYTE_W-1:0] rx_byte;
  logic byte_done, ack_end, in_ack, addr_hit;
  frame_state_t st;
  logic [CNT_W-1:0] nbytes;
  logic [WORD_W-1:0] word_acc;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i({sda_i, scl_i}),
    .sync_o(line_s), .prev_o(line_q)
  );

  assign scl_s    = line_s[0];
  assign sda_s    = line_s[1];
  assign scl_q    = line_q[0];
  assign sda_q    = line_q[1];
  assign start_ev = scl_s && scl_q && sda_q && !sda_s;
  assign stop_ev  = scl_s && scl_q && !sda_q && sda_s;
  assign scl_rise = scl_s && !scl_q;
  assign scl_fall = !scl_s && scl_q;

  i2c_bit_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .clear_i(start_ev || stop_ev || (st == FR_IDLE)),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .byte_o(rx_byte), .byte_done_o(byte_done), .ack_end_o(ack_end),
    .in_ack_o(in_ack)
  );

  assign addr_hit = (rx_byte[7:1] == own_addr_i) || (rx_byte[7:1] == GLOBAL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= FR_IDLE;
      nbytes      <= '0;
      word_acc    <= '0;
      sda_pull_o  <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_word_o  <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (start_ev) begin
        st         <= FR_ADDR;
        nbytes     <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_ev) begin
        st         <= FR_IDLE;
        sda_pull_o <= 1'b0;
      end else if (ack_end) begin
        sda_pull_o <= 1'b0;
      end else if (byte_done) begin
        case (st)
          FR_ADDR: begin
            if (addr_hit && !rx_byte[0]) begin
              st         <= FR_DATA;
              nbytes     <= '0;
              sda_pull_o <= 1'b1;
            end else begin
              st <= FR_SKIP;
            end
          end
          FR_DATA: begin
            if (nbytes != FULL) begin
              sda_pull_o <= 1'b1;
              nbytes     <= nbytes + CNT_W'(1);
              word_acc   <= {word_acc[WORD_W-BYTE_W-1:0], rx_byte};
              if (nbytes == LAST) begin
                cmd_valid_o <= 1'b1;
                cmd_word_o  <= {word_acc[WORD_W-BYTE_W-1:0], rx_byte};
              end
            end else begin
              st <= FR_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  pull_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> in_ack);
  // R2
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s);
  // R4
  read_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !start_ev && !stop_ev && (st == FR_ADDR) && rx_byte[0]) |=> !sda_pull_o);
  // R7
  extra_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !start_ev && !stop_ev && (st == FR_DATA) && (nbytes == FULL))
      |=> !sda_pull_o && !cmd_valid_o);
  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);
  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_pull_o);
endmodule

// File: tb/i2c_cmd_sink_bench.sv
module i2c_cmd_sink_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] own = 7'h2A;
  logic pull, vld, bus_sda;
  logic [23:0] word;
  assign bus_sda = sda_m & ~pull;

  i2c_cmd_sink u_i2c_cmd_sink (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
    .own_addr_i(own), .sda_pull_o(pull), .cmd_valid_o(vld), .cmd_word_o(word)
  );

  int checks = 0, errors = 0;
  logic [23:0] exp_q[$];
  logic [23:0] last_word = '0;
  int m_state = 0, m_n = 0;
  logic [23:0] m_acc = '0;
  bit ack_slot = 0, ack_exp = 0, prev_vld = 0, done = 0;
  string cur_tag = "R2";

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_start();
    m_state = 1; m_n = 0; m_acc = '0;
  endtask

  task automatic model_byte(input logic [7:0] b, output bit ack);
    ack = 0;
    if (m_state == 1) begin
      if (((b[7:1] == own) || (b[7:1] == 7'h73)) && !b[0]) begin
        m_state = 2; m_n = 0; ack = 1;
      end else m_state = 3;
    end else if (m_state == 2) begin
      if (m_n < 3) begin
        m_acc = {m_acc[15:0], b}; m_n++; ack = 1;
        if (m_n == 3) exp_q.push_back(m_acc);
      end else m_state = 3;
    end
  endtask

  task automatic send_bit(input bit v);
    scl_m = 1'b0; tick(3); sda_m = v; tick(7); scl_m = 1'b1; tick(10);
  endtask

  task automatic do_start();
    scl_m = 1'b0; tick(6); sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(10);
    sda_m = 1'b0; tick(10);
    model_start();
  endtask

  task automatic do_stop();
    scl_m = 1'b0; tick(6); sda_m = 1'b0; tick(4); scl_m = 1'b1; tick(10);
    sda_m = 1'b1; tick(10);
    m_state = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    bit exp;
    model_byte(b, exp);
    cur_tag = tag;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    scl_m = 1'b0; tick(3); sda_m = 1'b1; tick(7);
    ack_exp = exp; scl_m = 1'b1; ack_slot = 1; tick(5);
    checks++;
    if (pull !== exp) begin
      errors++;
      $display("FAIL %s ack for byte %h: actual %b expected %b", tag, b, pull, exp);
    end
    tick(5); ack_slot = 0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(b[i]);
  endtask

  task automatic check_drained(input string tag);
    tick(10);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s missing strobe: actual pending %0d expected 0", tag, exp_q.size());
      exp_q.delete();
    end
    checks++;
    if (word !== last_word) begin
      errors++;
      $display("FAIL %s word: actual %h expected %h", tag, word, last_word);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (scl_m) begin
        checks++;
        if (ack_slot ? (pull !== ack_exp) : (pull !== 1'b0)) begin
          errors++;
          $display("FAIL %s pull during SCL high: actual %b expected %b",
                   cur_tag, pull, ack_slot ? ack_exp : 1'b0);
        end
      end
      if (vld) begin
        checks++;
        if (prev_vld) begin
          errors++;
          $display("FAIL R11 strobe width: actual 2+ cycles expected 1");
        end else if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R7 R8 unexpected strobe: actual word %h expected none", word);
        end else begin
          last_word = exp_q.pop_front();
          if (word !== last_word) begin
            errors++;
            $display("FAIL R6 word: actual %h expected %h", word, last_word);
          end
        end
      end
      prev_vld = vld;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R1
    checks++; if (pull !== 1'b0) begin errors++; $display("FAIL R1 pull: actual %b expected 0", pull); end
    checks++; if (vld !== 1'b0) begin errors++; $display("FAIL R1 valid: actual %b expected 0", vld); end
    checks++; if (word !== 24'h0) begin errors++; $display("FAIL R1 word: actual %h expected 0", word); end

    // R2 and R6: local write, three bytes
    do_start(); send_byte(8'h54, "R2");
    send_byte(8'h3A, "R6"); send_byte(8'h5C, "R6"); send_byte(8'hE1, "R6");
    do_stop(); check_drained("R6");
    checks++;
    if (word[23:20] !== 4'h3 || word[19:16] !== 4'hA || word[15:0] !== 16'h5CE1) begin
      errors++; $display("FAIL R6 fields: actual %h expected 3a5ce1", word);
    end

    // R3: broadcast address
    do_start(); send_byte(8'hE6, "R3");
    send_byte(8'h01, "R3"); send_byte(8'h23, "R3"); send_byte(8'h45, "R3");
    do_stop(); check_drained("R3");

    // R4: reads to local and broadcast addresses
    do_start(); send_byte(8'h55, "R4"); send_byte(8'hFF, "R4"); do_stop(); check_drained("R4");
    do_start(); send_byte(8'hE7, "R4"); send_byte(8'h00, "R4"); do_stop(); check_drained("R4");

    // R5: other address
    do_start(); send_byte(8'h56, "R5");
    send_byte(8'h9A, "R5"); send_byte(8'hBC, "R5"); send_byte(8'hDE, "R5");
    do_stop(); check_drained("R5");

    // R7: over-length frame
    do_start(); send_byte(8'h54, "R2");
    send_byte(8'h11, "R6"); send_byte(8'h22, "R6"); send_byte(8'h33, "R6");
    send_byte(8'h44, "R7"); send_byte(8'h55, "R7");
    do_stop(); check_drained("R7");

    // R8: short frame
    do_start(); send_byte(8'h54, "R2"); send_byte(8'h99, "R8"); send_byte(8'h88, "R8");
    do_stop(); check_drained("R8");

    // R9: repeated START drops collected bytes
    do_start(); send_byte(8'h54, "R9"); send_byte(8'h77, "R9");
    do_start(); send_byte(8'hE6, "R9");
    send_byte(8'hAB, "R9"); send_byte(8'hCD, "R9"); send_byte(8'hEF, "R9");
    do_stop(); check_drained("R9");

    // R10: START and STOP in the middle of a byte
    do_start(); send_byte(8'h54, "R10"); send_byte(8'h6C, "R10"); send_bits(8'hA5, 4);
    do_start(); send_byte(8'h54, "R10");
    send_byte(8'h01, "R10"); send_byte(8'h02, "R10"); send_byte(8'h03, "R10");
    do_stop(); check_drained("R10");
    do_start(); send_byte(8'h54, "R10"); send_byte(8'h10, "R10"); send_bits(8'h5A, 3);
    do_stop(); check_drained("R10");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule